// File: doc/BRIEF.md
# Mode-Selected Address and General-Purpose Pin Port

This block controls one 8-pin port of a microcontroller. Each pin can carry a line of the low byte of the external address bus, or it can be a general-purpose input or output. The 3-bit operating mode sets the choice for the whole port. In some modes a per-pin direction bit then decides between address output and input. In other modes the direction bit decides between a general-purpose output and an input. Four registers sit on a plain register bus. They are a write-only direction register, an output data register, a read-only pin level view and a pull-up enable register.

Two reset inputs affect the registers differently. Power-on reset clears everything. Manual reset clears the data and pull-up registers but keeps the direction register, so the pin assignment survives it. Hardware standby floats every pin and clears all registers. Software standby keeps the registers. An input selects whether address pins keep driving their last value or release the line while software standby lasts. The register bus is a control path without back-pressure. A write completes at the clock edge that samples the strobe. Read data is combinational while the read strobe is high and is zero otherwise.

Top module: `addr_gpio_port`

## Requirements
- R1: An active-low power-on reset (`por_n`) clears the direction, data and pull-up registers to 0x00.
- R2: While `mrst_n` is low at a clock edge, the data and pull-up registers clear to 0x00. The direction register keeps its value, and bus writes at that edge are ignored.
- R3: While `hw_stby` is high, `pin_oe` and `pin_pullup` are all zero. Every register clears at each edge, and bus writes are ignored.
- R4: In modes 1, 4 and 5, every pin drives the matching bit of `addr_lo` with output enable set, whatever the direction register holds.
- R5: In modes 2 and 6, a pin whose direction bit is 1 drives its `addr_lo` bit. A pin whose direction bit is 0 is an input with output enable clear and output 0.
- R6: In modes 3 and 7, a pin whose direction bit is 1 drives its data register bit. A pin whose direction bit is 0 is an input.
- R7: In mode 0, all pins are inputs: `pin_oe` is 0x00 and `pin_out` is 0x00.
- R8: In software standby, general-purpose outputs and the registers are unchanged. Address pins drive the `addr_lo` value sampled at the last edge before standby began when `stby_hold` is 1, and they have output enable clear when `stby_hold` is 0.
- R9: A read of offset 1 returns the data bit for each general-purpose output pin. For every other pin it returns `pin_in` after a two-flop synchronizer, so a change becomes visible after the second clock edge.
- R10: `pin_pullup[i]` is 1 only when pull-up bit i is 1 and pin i is acting as an input.
- R11: Register offsets on `bus_addr` are 0 for data (read/write), 1 for pin levels (writes ignored), 2 for pull-up (read/write) and 3 for direction (write-only, reads 0xFF). `bus_rdata` is 0x00 when `bus_rd` is low.
- R12: A write takes effect at the rising clock edge that samples `bus_wr` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mrst_n | input | 1 | Manual reset, active low, synchronous |
| hw_stby | input | 1 | Hardware standby |
| sw_stby | input | 1 | Software standby |
| stby_hold | input | 1 | 1: address pins hold in software standby; 0: they float |
| mode | input | 3 | Operating mode |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| addr_lo | input | 8 | Low byte of the internal address bus |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Output value per pin |
| pin_oe | output | 8 | Output enable per pin |
| pin_pullup | output | 8 | Pull-up enable per pin |

## Verification
The bench targets the asymmetry between the two resets. A design that cleared direction on manual reset would drop its output enables after the pulse. One that kept data would still drive the old value. Hardware standby is checked with writes attempted during it, which catches a design that floats the pins but still accepts writes. Software standby is checked with the address bus changing after entry: a design that kept passing the live address through, or ignored the hold control, shows the wrong byte or the wrong enable. The mode walk and the synchronizer timing catch a mis-grouped mode, pull-ups left on for driven pins, and a readback that is one cycle early or late.

// File: rtl/addr_port_pkg.sv
package addr_port_pkg;

  typedef enum logic [1:0] {
    FN_INPUT = 2'd0,
    FN_ADDR  = 2'd1,
    FN_GPIO  = 2'd2
  } pin_fn_e;

  typedef enum logic [1:0] {
    MC_NONE     = 2'd0,
    MC_ALL_ADDR = 2'd1,
    MC_DIR_ADDR = 2'd2,
    MC_DIR_GPIO = 2'd3
  } mode_cls_e;

  localparam logic [1:0] OFS_DATA = 2'd0;
  localparam logic [1:0] OFS_PINS = 2'd1;
  localparam logic [1:0] OFS_PULL = 2'd2;
  localparam logic [1:0] OFS_DIR  = 2'd3;

  function automatic mode_cls_e classify_mode(input logic [2:0] m);
    case (m)
      3'd1, 3'd4, 3'd5: classify_mode = MC_ALL_ADDR;
      3'd2, 3'd6:       classify_mode = MC_DIR_ADDR;
      3'd3, 3'd7:       classify_mode = MC_DIR_GPIO;
      default:          classify_mode = MC_NONE;
    endcase
  endfunction

endpackage

// File: rtl/addr_port_regs.sv
module addr_port_regs
  import addr_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         mrst_n,
  input  logic         hw_stby,
  input  logic         wr_en,
  input  logic [1:0]   wr_ofs,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] data_q,
  output logic [W-1:0] pu_q
);

  logic wr_ok;
  assign wr_ok = wr_en && mrst_n && !hw_stby;

  // direction: cleared by power-on reset and hardware standby only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      dir_q <= '0;
    end else if (hw_stby) begin
      dir_q <= '0;
    end else if (wr_ok && wr_ofs == OFS_DIR) begin
      dir_q <= wr_data;
    end
  end

  // data and pull-up: also cleared by manual reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      data_q <= '0;
      pu_q   <= '0;
    end else if (hw_stby || !mrst_n) begin
      data_q <= '0;
      pu_q   <= '0;
    end else if (wr_ok) begin
      if (wr_ofs == OFS_DATA) data_q <= wr_data;
      if (wr_ofs == OFS_PULL) pu_q   <= wr_data;
    end
  end

  AST_DIR_KEPT_MRST: assert property (@(posedge clk) disable iff (!por_n)
    (!mrst_n && !hw_stby) |=> $stable(dir_q)); // R2
  AST_REGS_CLR_MRST: assert property (@(posedge clk) disable iff (!por_n)
    (!mrst_n) |=> (data_q == '0 && pu_q == '0)); // R2
  AST_HWSTBY_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    hw_stby |=> (dir_q == '0 && data_q == '0 && pu_q == '0)); // R3
  AST_PINS_WR_IGNORED: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && wr_ofs == OFS_PINS && mrst_n && !hw_stby) |=> ($stable(data_q) && $stable(pu_q) && $stable(dir_q))); // R11

endmodule

// File: rtl/addr_port_sync.sv
module addr_port_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/addr_port_pinmux.sv
module addr_port_pinmux
  import addr_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [2:0]   mode,
  input  logic         hw_stby,
  input  logic         sw_stby,
  input  logic         stby_hold,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] data_q,
  input  logic [W-1:0] pu_q,
  input  logic [W-1:0] addr_lo,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_pullup,
  output logic [W-1:0] gpio_mask
);

  mode_cls_e    mcls;
  logic [W-1:0] addr_held_q;
  logic [W-1:0] addr_src;
  logic         addr_drive;

  assign mcls = classify_mode(mode);

  // capture the address each cycle outside software standby
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        addr_held_q <= '0;
    else if (!sw_stby) addr_held_q <= addr_lo;
  end

  assign addr_src   = sw_stby ? addr_held_q : addr_lo;
  assign addr_drive = !hw_stby && (!sw_stby || stby_hold);

  for (genvar i = 0; i < W; i++) begin : g_pin
    pin_fn_e fn;
    assign fn = (mcls == MC_ALL_ADDR)               ? FN_ADDR :
                (mcls == MC_DIR_ADDR && dir_q[i])   ? FN_ADDR :
                (mcls == MC_DIR_GPIO && dir_q[i])   ? FN_GPIO : FN_INPUT;
    assign pin_out[i]    = (fn == FN_ADDR) ? addr_src[i] :
                           (fn == FN_GPIO) ? data_q[i]   : 1'b0;
    assign pin_oe[i]     = (fn == FN_ADDR) ? addr_drive  :
                           (fn == FN_GPIO) ? !hw_stby    : 1'b0;
    assign pin_pullup[i] = pu_q[i] && (fn == FN_INPUT) && !hw_stby;
    assign gpio_mask[i]  = (fn == FN_GPIO);
  end

  AST_PULL_NOT_ON_OUT: assert property (@(posedge clk) disable iff (!por_n)
    (pin_pullup & pin_oe) == '0); // R10
  AST_HW_FLOAT: assert property (@(posedge clk) disable iff (!por_n)
    hw_stby |-> (pin_oe == '0 && pin_pullup == '0)); // R3
  AST_ALL_ADDR_DRIVE: assert property (@(posedge clk) disable iff (!por_n)
    (mcls == MC_ALL_ADDR && !hw_stby && !sw_stby) |-> (pin_oe == '1 && pin_out == addr_lo)); // R4
  AST_STBY_ADDR_HELD: assert property (@(posedge clk) disable iff (!por_n)
    (sw_stby && $past(sw_stby) && stby_hold && !hw_stby && mcls == MC_ALL_ADDR && $stable(mode)) |-> $stable(pin_out)); // R8
  AST_MODE0_INPUT: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 3'd0) |-> (pin_oe == '0)); // R7

endmodule

// File: rtl/addr_gpio_port.sv
module addr_gpio_port
  import addr_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         mrst_n,
  input  logic         hw_stby,
  input  logic         sw_stby,
  input  logic         stby_hold,
  input  logic [2:0]   mode,
  input  logic [1:0]   bus_addr,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] addr_lo,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_pullup
);

  logic [W-1:0] dir_q, data_q, pu_q, pin_sync, gpio_mask;

  addr_port_regs #(.W(W)) regs_i (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .hw_stby(hw_stby),
    .wr_en(bus_wr), .wr_ofs(bus_addr), .wr_data(bus_wdata),
    .dir_q(dir_q), .data_q(data_q), .pu_q(pu_q)
  );

  addr_port_sync #(.W(W), .STAGES(2)) sync_i (
    .clk(clk), .por_n(por_n), .d(pin_in), .q(pin_sync)
  );

  addr_port_pinmux #(.W(W)) mux_i (
    .clk(clk), .por_n(por_n), .mode(mode), .hw_stby(hw_stby),
    .sw_stby(sw_stby), .stby_hold(stby_hold), .dir_q(dir_q),
    .data_q(data_q), .pu_q(pu_q), .addr_lo(addr_lo),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pullup(pin_pullup),
    .gpio_mask(gpio_mask)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFS_DATA: bus_rdata = data_q;
        OFS_PINS: bus_rdata = (data_q & gpio_mask) | (pin_sync & ~gpio_mask);
        OFS_PULL: bus_rdata = pu_q;
        default:  bus_rdata = '1;
      endcase
    end
  end

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    !bus_rd |-> (bus_rdata == '0)); // R11
  AST_WR_LANDS: assert property (@(posedge clk) disable iff (!por_n)
    (bus_wr && bus_addr == OFS_DATA && mrst_n && !hw_stby) |=> (data_q == $past(bus_wdata))); // R12

endmodule

// File: tb/addr_gpio_port_tb_top.sv
module addr_gpio_port_tb_top;

  logic       clk = 1'b0;
  logic       por_n = 1'b0, mrst_n = 1'b1, hw_stby = 1'b0, sw_stby = 1'b0, stby_hold = 1'b1;
  logic [2:0] mode = 3'd3;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00, addr_lo = 8'hA5, pin_in = 8'h96;
  logic [7:0] bus_rdata, pin_out, pin_oe, pin_pullup;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  addr_gpio_port dut_i (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .hw_stby(hw_stby),
    .sw_stby(sw_stby), .stby_hold(stby_hold), .mode(mode),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .addr_lo(addr_lo),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pullup(pin_pullup)
  );

  // mode, expected oe, out, pullup, pin readback
  // setup: dir=0F data=3C pull=FF addr_lo=A5 pin_in=96
  localparam logic [35:0] VEC [8] = '{
    {4'd0, 8'h00, 8'h00, 8'hFF, 8'h96},
    {4'd1, 8'hFF, 8'hA5, 8'h00, 8'h96},
    {4'd2, 8'h0F, 8'h05, 8'hF0, 8'h96},
    {4'd3, 8'h0F, 8'h0C, 8'hF0, 8'h9C},
    {4'd4, 8'hFF, 8'hA5, 8'h00, 8'h96},
    {4'd5, 8'hFF, 8'hA5, 8'h00, 8'h96},
    {4'd6, 8'h0F, 8'h05, 8'hF0, 8'h96},
    {4'd7, 8'h0F, 8'h0C, 8'hF0, 8'h9C}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    bus_rd = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    #1 chk("R1 oe after por", pin_oe, 8'h00);
    rd(2'd0, v); chk("R1 data after por", v, 8'h00);
    rd(2'd2, v); chk("R1 pull after por", v, 8'h00);
    rd(2'd3, v); chk("R11 dir reads ones", v, 8'hFF);
    #1 chk("R11 idle rdata", bus_rdata, 8'h00);

    // R12 write lands at the sampling edge
    @(negedge clk);
    bus_addr = 2'd0; bus_wdata = 8'h3C; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
    bus_rd = 1'b1; #1 chk("R12 data after edge", bus_rdata, 8'h3C);
    bus_rd = 1'b0;
    wr(2'd3, 8'h0F);
    wr(2'd2, 8'hFF);
    wr(2'd1, 8'h00);
    rd(2'd0, v); chk("R11 pins write ignored", v, 8'h3C);

    // mode walk R4 R5 R6 R7 R9 R10
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      mode = VEC[k][34:32];
      #1;
      chk($sformatf("R4/R5/R6/R7 oe mode %0d", k), pin_oe, VEC[k][31:24]);
      chk($sformatf("R4/R5/R6/R7 out mode %0d", k), pin_out, VEC[k][23:16]);
      chk($sformatf("R10 pullup mode %0d", k), pin_pullup, VEC[k][15:8]);
      rd(2'd1, v);
      chk($sformatf("R9 readback mode %0d", k), v, VEC[k][7:0]);
    end

    // R9 synchronizer latency (mode 0, all inputs)
    @(negedge clk); mode = 3'd0; pin_in = 8'h5B;
    @(posedge clk); #1 bus_addr = 2'd1; bus_rd = 1'b1;
    #1 chk("R9 after one edge", bus_rdata, 8'h96);
    @(posedge clk); #1 chk("R9 after two edges", bus_rdata, 8'h5B);
    bus_rd = 1'b0;

    // R2 manual reset
    @(negedge clk); mode = 3'd3; mrst_n = 1'b0;
    @(negedge clk); mrst_n = 1'b1;
    #1 chk("R2 dir kept oe", pin_oe, 8'h0F);
    chk("R2 data cleared out", pin_out, 8'h00);
    rd(2'd2, v); chk("R2 pull cleared", v, 8'h00);

    // R8 software standby with hold
    wr(2'd0, 8'h0A);
    @(negedge clk); mode = 3'd1; addr_lo = 8'h5A;
    @(negedge clk); sw_stby = 1'b1; stby_hold = 1'b1; addr_lo = 8'h11;
    @(negedge clk); #1;
    chk("R8 held addr", pin_out, 8'h5A);
    chk("R8 hold oe", pin_oe, 8'hFF);
    stby_hold = 1'b0; #1;
    chk("R8 float oe", pin_oe, 8'h00);
    mode = 3'd3; #1;
    chk("R8 gpio oe in stby", pin_oe, 8'h0F);
    chk("R8 gpio out in stby", pin_out, 8'h0A);
    @(negedge clk); sw_stby = 1'b0; stby_hold = 1'b1;
    #1 chk("R8 dir kept after stby", pin_oe, 8'h0F);

    // R3 hardware standby
    @(negedge clk); mode = 3'd1; wr(2'd2, 8'hF0);
    @(negedge clk); mode = 3'd0; hw_stby = 1'b1;
    #1 chk("R3 pullup off", pin_pullup, 8'h00);
    mode = 3'd1; #1 chk("R3 oe off", pin_oe, 8'h00);
    wr(2'd3, 8'hFF);
    wr(2'd0, 8'h77);
    @(negedge clk); hw_stby = 1'b0; mode = 3'd3;
    #1 chk("R3 dir cleared", pin_oe, 8'h00);
    rd(2'd0, v); chk("R3 data cleared", v, 8'h00);
    rd(2'd2, v); chk("R3 pull cleared", v, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule